// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This peripheral holds two identical timer/counters behind a small word-addressed register bus. Each one has a control/status word, a load value and a live count. A timer can count up or down. With reload enabled it runs without stopping, and with reload clear it stops once. Software can force a timer's count to its load value, and a single control write can start both timers together. Each timer can raise a sticky event flag. That flag is cleared by writing a one to it, and it can be routed to one shared level interrupt.

In a typical system, timer 0 counts down with reload set and acts as a periodic tick. Timer 1 counts up with its interrupt masked and acts as a free-running time base that software reads at any moment. The external-trigger, capture and pulse-width bits are kept as storage only: they read back but change nothing.

Top module: `dual_timer`

## Requirements
- R1: Byte offsets 0x00/0x04/0x08 select the control, load and count words of timer 0, and 0x10/0x14/0x18 select those of timer 1. Address bits [1:0] are ignored. Offsets 0x0C and 0x1C read as zero. Read data appears on the clock edge after the one where the address is presented.
- R2: The control bit positions are: 0 mode, 1 count down, 2 external trigger, 3 capture, 4 reload, 5 load, 6 interrupt enable, 7 run, 8 event status, 9 pulse-width, 10 start-both. Every bit except 8 reads back as written. Bits 0, 2, 3 and 9 do not change how the counter behaves.
- R3: While control bit 5 is 1, the count takes the load value on every edge and does not advance.
- R4: When counting down with reload set, a count at 0 is replaced by the load value L on the next edge. Event status is set on the edge where the count steps to 0, so events repeat every L+1 cycles.
- R5: When counting up with reload set, a count at all-ones is replaced by the load value. Event status is set on the edge where the count steps to all-ones.
- R6: With reload clear, the counter stops at its terminal value (0 down, all-ones up) and holds it. The run bit stays 1.
- R7: With the run bit at 0 and bit 5 at 0, the count holds its value.
- R8: A control write with bit 8 at 1 clears event status. A control write with bit 8 at 0 leaves it unchanged.
- R9: When a status clear and a new event fall on the same edge, the status ends up set.
- R10: A control write to either timer with bit 10 at 1 sets the run bit of both timers on that edge.
- R11: `irq` is registered and equals the OR over both timers of (status AND interrupt enable) one edge later. It stays 0 when both enables are 0.
- R12: Synchronous reset clears every register, the read data and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can land on the same edge: software acknowledging an event, and the counter producing the next event. The bench provokes this with timer 0 counting down from a load value of 1, so an event falls on every second edge. The acknowledge write is placed on an edge where an event also falls. The request must then stay high on each of the following three cycles; if the clear won, the request would drop for a cycle. The bench also checks that both timers start on one edge under start-both, by reading an up counter and a down counter that begin at the same value and comparing the values read.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int BUS_ADDR_W = 5;
  localparam int TSEL_BIT   = 4;
  localparam int CTRL_W     = 11;
  localparam int B_MODE  = 0;
  localparam int B_DOWN  = 1;
  localparam int B_XTRG  = 2;
  localparam int B_CAPT  = 3;
  localparam int B_RELD  = 4;
  localparam int B_LOAD  = 5;
  localparam int B_IEN   = 6;
  localparam int B_RUN   = 7;
  localparam int B_STAT  = 8;
  localparam int B_PWM   = 9;
  localparam int B_BOTH  = 10;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dual_timer_chan.sv
module dual_timer_chan
  import dual_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_load,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic [CNT_W-1:0]  load_wdata,
  input  logic              start_all,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  load_q,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic             run, ld, down, reld;
  logic [CNT_W-1:0] step_val, tc_val, cnt_nxt;
  logic             at_tc, tc_evt;
  logic [CTRL_W-1:0] ctrl_nxt;

  assign run  = ctrl_q[B_RUN];
  assign ld   = ctrl_q[B_LOAD];
  assign down = ctrl_q[B_DOWN];
  assign reld = ctrl_q[B_RELD];

  always_comb begin
    step_val = down ? (cnt_q - 1'b1) : (cnt_q + 1'b1);
    tc_val   = down ? CNT_ZERO : CNT_MAX;
    at_tc    = (cnt_q == tc_val);
    tc_evt   = run && !ld && !at_tc && (step_val == tc_val);
    if (ld) begin
      cnt_nxt = load_q;
    end else if (run) begin
      if (at_tc) cnt_nxt = reld ? load_q : cnt_q;
      else       cnt_nxt = step_val;
    end else begin
      cnt_nxt = cnt_q;
    end
  end

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_ctrl) begin
      ctrl_nxt = ctrl_wdata;
      ctrl_nxt[B_STAT] = ctrl_q[B_STAT] & ~ctrl_wdata[B_STAT];
    end
    if (start_all) ctrl_nxt[B_RUN] = 1'b1;
    if (tc_evt)    ctrl_nxt[B_STAT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      cnt_q  <= cnt_nxt;
      if (wr_load) load_q <= load_wdata;
    end
  end

  // R3
  ld_force_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[B_LOAD] |=> (cnt_q == $past(load_q)));
  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[B_RUN] && !ctrl_q[B_LOAD]) |=> $stable(cnt_q));
  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !ld && !reld && at_tc) |=> $stable(cnt_q));
  // R9
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    tc_evt |=> ctrl_q[B_STAT]);
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic                  bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq
);
  localparam int N_TMR = 2;

  reg_sel_e          sel;
  logic              tsel;
  logic [N_TMR-1:0]  wr_ctrl, wr_load, req;
  logic              start_all;
  logic [CTRL_W-1:0] ctrl_q [N_TMR];
  logic [CNT_W-1:0]  load_q [N_TMR];
  logic [CNT_W-1:0]  cnt_q  [N_TMR];
  logic [DATA_W-1:0] rd_nxt;

  assign sel  = reg_sel_e'(bus_addr[3:2]);
  assign tsel = bus_addr[TSEL_BIT];
  assign start_all = (|wr_ctrl) & bus_wdata[B_BOTH];

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    assign wr_ctrl[g] = bus_we && (tsel == g[0]) && (sel == SEL_CTRL);
    assign wr_load[g] = bus_we && (tsel == g[0]) && (sel == SEL_LOAD);
    assign req[g]     = ctrl_q[g][B_STAT] & ctrl_q[g][B_IEN];

    dual_timer_chan #(.CNT_W(CNT_W)) chan_i (
      .clk        (clk),
      .rst        (rst),
      .wr_ctrl    (wr_ctrl[g]),
      .wr_load    (wr_load[g]),
      .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
      .load_wdata (bus_wdata[CNT_W-1:0]),
      .start_all  (start_all),
      .ctrl_q     (ctrl_q[g]),
      .load_q     (load_q[g]),
      .cnt_q      (cnt_q[g])
    );
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_nxt = DATA_W'(ctrl_q[tsel]);
      SEL_LOAD: rd_nxt = DATA_W'(load_q[tsel]);
      SEL_CNT:  rd_nxt = DATA_W'(cnt_q[tsel]);
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_nxt;
      irq       <= |req;
    end
  end

  // R1
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[3:2] == 2'b11) |=> (bus_rdata == '0));
  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0][B_STAT] && ctrl_q[0][B_IEN]) |=> irq);
  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0][B_IEN] && !ctrl_q[1][B_IEN]) |=> !irq);
  // R10
  both_start_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr[3:2] == 2'b00 && bus_wdata[B_BOTH])
      |=> (ctrl_q[0][B_RUN] && ctrl_q[1][B_RUN]));
endmodule

// File: tb/dual_timer_tb_top.sv
module dual_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_timer #(.DATA_W(32), .CNT_W(8)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  localparam logic [31:0] C_DOWN = 32'h002, C_RELD = 32'h010, C_LOAD = 32'h020,
                          C_IEN = 32'h040, C_RUN = 32'h080, C_STAT = 32'h100,
                          C_BOTH = 32'h400;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a0, b0;
    int k, m;
    bit held;
    step(3);
    rst = 1'b0;
    // R12 reset state
    chk("R12 irq", {31'd0, irq}, 0);
    for (int r = 0; r < 8; r++) begin
      rd({r[2], r[1:0], 2'b00}, v);
      chk("R12 reg", v, 0);
    end
    // R1 load registers and address map
    wr(5'h04, 32'h5A);
    wr(5'h14, 32'hC3);
    rd(5'h04, v); chk("R1 load0", v, 32'h5A);
    rd(5'h17, v); chk("R1 load1 low bits ignored", v, 32'hC3);
    // R3 load strobe held forces count
    wr(5'h00, C_LOAD | C_RUN | C_DOWN | C_STAT);
    step(4);
    rd(5'h08, v); chk("R3 held count", v, 32'h5A);
    step(3);
    rd(5'h08, v); chk("R3 still held", v, 32'h5A);
    // R4 periodic down count, sweep of load values
    for (int L = 1; L <= 9; L++) begin
      wr(5'h04, L);
      wr(5'h00, C_LOAD | C_STAT);
      wr(5'h00, C_RUN | C_DOWN | C_RELD | C_IEN | C_STAT);
      k = 0;
      while (!irq && k < 100) begin @(negedge clk); k++; end
      chk("R4 first event delay", k, L + 1);
      wr(5'h00, C_RUN | C_DOWN | C_RELD | C_IEN | C_STAT);
      if (L == 1) begin
        // R9 acknowledge lands on an event edge
        held = 1'b1;
        for (int i = 0; i < 3; i++) begin @(negedge clk); if (!irq) held = 1'b0; end
        chk("R9 event beats clear", {31'd0, held}, 1);
      end else begin
        m = 0;
        while (irq && m < 100) begin @(negedge clk); m++; end
        while (!irq && m < 100) begin @(negedge clk); m++; end
        chk("R4 period", m, L);
      end
      wr(5'h00, C_STAT);
    end
    // R5 up count with reload, free running on timer 1
    wr(5'h14, 32'hF0);
    wr(5'h10, C_LOAD | C_STAT);
    wr(5'h10, C_RUN | C_RELD);
    for (int i = 0; i < 40; i++) begin
      rd(5'h18, v);
      chk("R5 free count", v, 32'hF0 + (i % 16));
    end
    // R11 no request while enables are clear
    chk("R11 masked irq", {31'd0, irq}, 0);
    rd(5'h10, v); chk("R5 wrap sets status", v & C_STAT, C_STAT);
    // R6 one-shot down count
    wr(5'h04, 4);
    wr(5'h00, C_LOAD | C_STAT);
    wr(5'h00, C_RUN | C_DOWN | C_IEN);
    k = 0;
    while (!irq && k < 100) begin @(negedge clk); k++; end
    chk("R6 one-shot delay", k, 5);
    // R8 write with status bit at 0 keeps the event
    wr(5'h00, C_RUN | C_DOWN | C_IEN);
    step(2);
    chk("R8 no clear on zero", {31'd0, irq}, 1);
    rd(5'h08, v); chk("R6 held at zero", v, 0);
    rd(5'h00, v); chk("R6 run bit kept", v, 32'h1C2);
    // R8 write back the value read to acknowledge
    wr(5'h00, v);
    @(negedge clk);
    chk("R8 cleared", {31'd0, irq}, 0);
    step(5);
    chk("R6 no retrigger", {31'd0, irq}, 0);
    // R7 stop holds the count
    wr(5'h10, C_RELD);
    rd(5'h18, a0);
    step(5);
    rd(5'h18, b0);
    chk("R7 stopped", b0, a0);
    // R10 start both timers in one write
    wr(5'h04, 32'h20);
    wr(5'h14, 32'h20);
    wr(5'h10, C_LOAD | C_STAT);
    wr(5'h10, 0);
    wr(5'h00, C_LOAD | C_STAT);
    wr(5'h00, C_DOWN | C_BOTH);
    rd(5'h08, v); chk("R10 timer0 count", v, 32'h20);
    rd(5'h18, v); chk("R10 timer1 count", v, 32'h21);
    rd(5'h10, v); chk("R10 timer1 run", v & ~C_STAT, C_RUN);
    rd(5'h00, v); chk("R2 ctrl0 readback", v & ~C_STAT, 32'h482);
    // R2 inert control bits
    wr(5'h00, C_STAT);
    wr(5'h10, 32'h28D);
    rd(5'h10, v); chk("R2 ctrl1 readback", v & ~C_STAT, 32'h28D);
    rd(5'h18, a0);
    rd(5'h18, b0);
    chk("R2 bits inert", b0, a0 + 1);
    // R1 unmapped offsets
    rd(5'h0C, v); chk("R1 hole 0x0C", v, 0);
    rd(5'h1C, v); chk("R1 hole 0x1C", v, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule